// File: doc/BRIEF.md
# Fixed-OR Programmable Array Logic

This block is a behavioural model of a small programmable logic device whose AND plane is configurable and whose OR plane is hard-wired. A serial configuration port loads a fuse map. For every product term, the map selects which true and complemented signal literals take part in the AND. Each output owns a private group of sum terms, which are ORed together and then inverted on the way to the pin. Each output also owns one extra product term that drives its three-state enable.

Six of the output pins are bidirectional. The level sensed on each of those pads, whether the block drives it or something outside does, is fed back into the AND plane as an extra array signal. Pads are modelled as separate data and enable outputs plus a sensed-level input, so the model contains no tristate nets. Whoever instantiates it resolves the pad level. The evaluation path from the inputs to the pins is purely combinational. Only the fuse store is clocked.

Top module: `pal_fixed_or`

## Requirements
- R1: After a synchronous reset every fuse is intact (value 1), so `pin_data` reads all ones and `pin_oe` reads all zeros for any input levels.
- R2: While `prog_en` is high, each rising clock edge shifts `prog_bit` into the fuse store. After 2048 such edges, the bit presented on the k-th edge (k counted from 0) sits at fuse index k. The fuse index is `(out*8 + t)*32 + lit`. Here t is 0..6 for the sum terms and 7 for the enable term. lit is `2*s` for the true literal of array signal s and `2*s+1` for its complement. Signal s is `in_i[s]` for s 0..9 and `pad_in[s-10]` for s 10..15. A fuse value of 1 connects the literal and 0 disconnects it.
- R3: While `prog_en` is low, clock edges and `prog_bit` have no effect on the fuse store or on the outputs.
- R4: While `prog_en` is high, every bit of `pin_oe` is 0.
- R5: A product term is the AND of its connected literals. A term with no connected literal is 1. A term with both polarities of one signal connected is 0.
- R6: `pin_data[o]` is the complement of the OR of output o's own seven sum terms. No term of another output affects it.
- R7: With `prog_en` low, `pin_oe[o]` equals output o's enable product term, independently for each output.
- R8: `pad_in[b]` (b 0..5) is the sensed level of bidirectional output pin b. It reaches the AND plane as array signal 10+b.
- R9: A change on `in_i` or `pad_in` appears at `pin_data` and `pin_oe` without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the fuse store |
| rst | input | 1 | Synchronous active-high reset, restores all fuses to intact |
| prog_en | input | 1 | Configuration strobe; shift enable and output quiet |
| prog_bit | input | 1 | Serial fuse data |
| in_i | input | 10 | Dedicated array inputs |
| pad_in | input | 6 | Sensed levels of the bidirectional pins 0..5 |
| pin_data | output | 8 | Value each pin would drive (inverted sum) |
| pin_oe | output | 8 | Per-pin drive enable |

## Verification
A single wrong fuse bit is invisible until some input pattern satisfies every other literal of its product term. The bench therefore uses sparse random maps and many input vectors per map, so that each term is switched both on and off. A misplaced shift or a wrong index in the fuse layout shows up at once as a wrong output bit for the very first vector after a load. This is checked both by random maps and by a directed map that places single literals at known positions. Errors on the feedback path or in the inversion show in the same combinational settle time after `pad_in` or `in_i` change, with no clock needed.

// File: rtl/pal_pkg.sv
package pal_pkg;
  // Default geometry of the device.
  localparam int DEF_N_IN    = 10;
  localparam int DEF_N_OUT   = 8;
  localparam int DEF_N_BIDIR = 6;
  localparam int DEF_N_SUM   = 7;

  // Position of one fuse in the serial map.
  function automatic int fuse_pos(input int out_idx, input int term_idx,
                                  input int lit_idx, input int terms_per_out,
                                  input int lits_per_term);
    return (out_idx * terms_per_out + term_idx) * lits_per_term + lit_idx;
  endfunction
endpackage

// File: rtl/pal_fuse_chain.sv
module pal_fuse_chain #(
  parameter int MAP_BITS = 2048
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                shift_en,
  input  logic                shift_bit,
  output logic [MAP_BITS-1:0] fuse_o
);
  logic [MAP_BITS-1:0] store_q;

  always_ff @(posedge clk) begin
    if (rst)
      store_q <= '1;
    else if (shift_en)
      store_q <= {shift_bit, store_q[MAP_BITS-1:1]};
  end

  assign fuse_o = store_q;

  // R2: the newest bit enters at the top, the rest move down by one
  p_shift_entry_r2: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> store_q[MAP_BITS-1] == $past(shift_bit));
  p_shift_move_r2: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> store_q[MAP_BITS-2:0] == $past(store_q[MAP_BITS-1:1]));
  // R3: without the strobe the map is frozen
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(store_q));
endmodule

// File: rtl/pal_and_plane.sv
module pal_and_plane #(
  parameter int N_SIG = 16,
  parameter int N_PT  = 64,
  localparam int N_LIT = 2 * N_SIG
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N_SIG-1:0]      sig_i,
  input  logic [N_PT*N_LIT-1:0] fuse_i,
  output logic [N_PT-1:0]       pt_o
);
  logic [N_LIT-1:0] lit;

  for (genvar s = 0; s < N_SIG; s++) begin : g_lit
    assign lit[2*s]   = sig_i[s];
    assign lit[2*s+1] = ~sig_i[s];
  end

  for (genvar p = 0; p < N_PT; p++) begin : g_pt
    logic [N_LIT-1:0] row;
    assign row     = fuse_i[p*N_LIT +: N_LIT];
    // a disconnected literal does not constrain the term
    assign pt_o[p] = &(lit | ~row);

    // R5: contradictory literals force the term low
    p_contra_r5: assert property (@(posedge clk) disable iff (rst)
      (row[1:0] == 2'b11) |-> !pt_o[p]);
    // R5: a term with no literal connected is high
    p_empty_r5: assert property (@(posedge clk) disable iff (rst)
      (row == '0) |-> pt_o[p]);
  end
endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell #(
  parameter int N_SUM = 7
) (
  input  logic [N_SUM:0] terms_i,
  input  logic           quiet_i,
  output logic           data_o,
  output logic           oe_o
);
  logic sum;

  assign sum    = |terms_i[N_SUM-1:0];
  assign data_o = ~sum;
  assign oe_o   = terms_i[N_SUM] & ~quiet_i;
endmodule

// File: rtl/pal_fixed_or.sv
module pal_fixed_or #(
  parameter int N_IN    = pal_pkg::DEF_N_IN,
  parameter int N_OUT   = pal_pkg::DEF_N_OUT,
  parameter int N_BIDIR = pal_pkg::DEF_N_BIDIR,
  parameter int N_SUM   = pal_pkg::DEF_N_SUM
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               prog_en,
  input  logic               prog_bit,
  input  logic [N_IN-1:0]    in_i,
  input  logic [N_BIDIR-1:0] pad_in,
  output logic [N_OUT-1:0]   pin_data,
  output logic [N_OUT-1:0]   pin_oe
);
  localparam int N_SIG    = N_IN + N_BIDIR;
  localparam int N_LIT    = 2 * N_SIG;
  localparam int PT_OUT   = N_SUM + 1;
  localparam int N_PT     = N_OUT * PT_OUT;
  localparam int MAP_BITS = N_PT * N_LIT;

  logic [MAP_BITS-1:0] fuse;
  logic [N_SIG-1:0]    sig;
  logic [N_PT-1:0]     pt;
  logic                rst_q;

  // feedback pads follow the dedicated inputs in the signal order
  assign sig = {pad_in, in_i};

  pal_fuse_chain #(.MAP_BITS(MAP_BITS)) fuse_i (
    .clk(clk), .rst(rst), .shift_en(prog_en), .shift_bit(prog_bit),
    .fuse_o(fuse)
  );

  pal_and_plane #(.N_SIG(N_SIG), .N_PT(N_PT)) plane_i (
    .clk(clk), .rst(rst), .sig_i(sig), .fuse_i(fuse), .pt_o(pt)
  );

  for (genvar o = 0; o < N_OUT; o++) begin : g_cell
    pal_macrocell #(.N_SUM(N_SUM)) cell_i (
      .terms_i(pt[o*PT_OUT +: PT_OUT]),
      .quiet_i(prog_en),
      .data_o (pin_data[o]),
      .oe_o   (pin_oe[o])
    );
  end

  always_ff @(posedge clk) rst_q <= rst;

  // R1: a freshly reset map drives nothing and reads all ones
  p_reset_state_r1: assert property (@(posedge clk)
    rst_q |-> (pin_data == '1 && pin_oe == '0));
  // R4: no pin is driven while the map is being loaded
  p_quiet_prog_r4: assert property (@(posedge clk) disable iff (rst)
    prog_en |-> pin_oe == '0);
endmodule

// File: tb/pal_fixed_or_tb.sv
module pal_fixed_or_tb_top;
  localparam int N_IN = 10, N_OUT = 8, N_BIDIR = 6, N_SUM = 7;
  localparam int N_SIG = N_IN + N_BIDIR, N_LIT = 2 * N_SIG;
  localparam int PT_OUT = N_SUM + 1, N_PT = N_OUT * PT_OUT;
  localparam int MAP = N_PT * N_LIT;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic prog_en = 1'b0;
  logic prog_bit = 1'b0;
  logic [N_IN-1:0] in_i = '0;
  logic [N_BIDIR-1:0] pad_in = '0;
  logic [N_OUT-1:0] pin_data, pin_oe;

  logic [MAP-1:0] fmap;
  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pal_fixed_or dut_i (
    .clk(clk), .rst(rst), .prog_en(prog_en), .prog_bit(prog_bit),
    .in_i(in_i), .pad_in(pad_in), .pin_data(pin_data), .pin_oe(pin_oe)
  );

  function automatic int fidx(int o, int t, int l);
    return (o * PT_OUT + t) * N_LIT + l;
  endfunction

  function automatic logic term_val(int p, logic [N_SIG-1:0] s);
    for (int l = 0; l < N_LIT; l++) begin
      logic v;
      v = l[0] ? ~s[l/2] : s[l/2];
      if (fmap[p*N_LIT + l] && !v) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic logic [N_OUT-1:0] exp_data(logic [N_SIG-1:0] s);
    logic [N_OUT-1:0] r;
    for (int o = 0; o < N_OUT; o++) begin
      logic acc;
      acc = 1'b0;
      for (int t = 0; t < N_SUM; t++) acc |= term_val(o*PT_OUT + t, s);
      r[o] = ~acc;
    end
    return r;
  endfunction

  function automatic logic [N_OUT-1:0] exp_oe(logic [N_SIG-1:0] s);
    logic [N_OUT-1:0] r;
    for (int o = 0; o < N_OUT; o++) r[o] = term_val(o*PT_OUT + N_SUM, s);
    return r;
  endfunction

  task automatic check(string tag, logic [N_OUT-1:0] got, logic [N_OUT-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s got=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic check_model(string tag);
    logic [N_SIG-1:0] s;
    s = {pad_in, in_i};
    check({tag, " data"}, pin_data, exp_data(s));
    check({tag, " oe"}, pin_oe, exp_oe(s));
  endtask

  // R2 and R4: serial load in index order, oe sampled mid-load
  task automatic load_map();
    for (int k = 0; k < MAP; k++) begin
      @(negedge clk);
      prog_en = 1'b1;
      prog_bit = fmap[k];
      if (k == MAP / 2) begin
        #1;
        check("R4 oe during load", pin_oe, '0);
      end
    end
    @(negedge clk);
    prog_en = 1'b0;
    prog_bit = 1'b0;
    #1;
  endtask

  task automatic apply(logic [N_IN-1:0] a, logic [N_BIDIR-1:0] b);
    @(negedge clk);
    in_i = a;
    pad_in = b;
    #1;
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state under several input levels
    fmap = '1;
    for (int i = 0; i < 4; i++) begin
      apply(N_IN'($urandom), N_BIDIR'($urandom));
      check("R1 reset data", pin_data, '1);
      check("R1 reset oe", pin_oe, '0);
    end
    // R3: clocks with prog_en low and a toggling prog_bit change nothing
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      prog_bit = ~prog_bit;
    end
    #1;
    check("R3 no-strobe data", pin_data, '1);
    check("R3 no-strobe oe", pin_oe, '0);

    // R5 and R7: every fuse blown, all terms high
    fmap = '0;
    load_map();
    check("R5 blown data", pin_data, '0);
    check("R7 blown oe", pin_oe, '1);

    // R8 and R2: output b sum term 0 is the true pad literal b alone
    fmap = '1;
    for (int b = 0; b < N_BIDIR; b++) begin
      for (int l = 0; l < N_LIT; l++) begin
        fmap[fidx(b, 0, l)] = 1'b0;
        fmap[fidx(b, N_SUM, l)] = 1'b0;
      end
      fmap[fidx(b, 0, 2*(N_IN+b))] = 1'b1;
    end
    // R5: output 7 term 0 keeps only the two polarities of in_i[0]
    for (int l = 2; l < N_LIT; l++) fmap[fidx(7, 0, l)] = 1'b0;
    load_map();
    for (int i = 0; i < 8; i++) begin
      logic [N_BIDIR-1:0] pv;
      pv = N_BIDIR'($urandom);
      apply(N_IN'($urandom), pv);
      check("R8 pad feedback", pin_data, {2'b11, ~pv});
      check("R8 pad oe", pin_oe, {2'b00, 6'h3f});
    end
    // R9: combinational response without a clock edge
    @(negedge clk);
    pad_in = 6'h15;
    #0.5;
    check("R9 comb pad", pin_data, {2'b11, 6'h2a});
    pad_in = 6'h2a;
    #0.5;
    check("R9 comb pad", pin_data, {2'b11, 6'h15});

    // R6 and R7: random sparse maps and many vectors
    for (int m = 0; m < 5; m++) begin
      for (int k = 0; k < MAP; k++) fmap[k] = ($urandom % 7) == 0;
      load_map();
      for (int v = 0; v < 24; v++) begin
        apply(N_IN'($urandom), N_BIDIR'($urandom));
        check_model("R6 R7 random");
      end
      // R3: clocking with the strobe low leaves the function unchanged
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        prog_bit = 1'($urandom);
      end
      #1;
      check_model("R3 hold random");
    end

    // R9: input change between edges on the last random map
    @(posedge clk);
    #1;
    in_i = ~in_i;
    #0.5;
    check_model("R9 comb in");

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule